// File: doc/BRIEF.md
# Three-Wire Codec Control Bus Write Master

This block is a write-only master for a three-wire control bus that sets up an audio codec. The bus has a serial clock line, a serial data line and a mode line. A host pulses `start_i` and supplies a device code, a register-group selector, a data byte count (one or two by default) and the data bytes. The block then sends an address byte built from the code and the selector, followed by the data bytes, and raises `done_o` for one cycle when it has finished.

All bus timing comes from the system clock. There are five programmable counts: the clock-low time and clock-high time of each bit, the setup time before a byte, the hold time after a byte, and a halt gap. The halt gap comes before every data byte after the first. While the block is busy it drives the lines and holds `bus_oe_o` high. When it is idle it drives all three lines low and `bus_oe_o` low.

Top module: `tri_wire_ctl_master`

## Requirements
- R1: After reset and whenever idle, `busy_o`, `done_o`, `bus_oe_o`, `bus_clk_o`, `bus_dat_o` and `bus_mode_o` are all low.
- R2: In the cycle after an accepted start, `busy_o` and `bus_oe_o` rise, and clock, data and mode are all high for one cycle before the first setup interval.
- R3: Every byte is sent least-significant bit first, one bit per rising edge of `bus_clk_o`. The data line changes only while the bus clock is low.
- R4: The first byte sent is the address byte. Bits 7:2 carry `dev_i` and bits 1:0 carry `grp_i`. Mode is low on every rising edge of this byte.
- R5: The data bytes follow the address in order: byte 1 is `data_i[7:0]` and byte 2 is `data_i[15:8]`. Mode is high on every rising edge of these bytes.
- R6: For every bit, the clock is low for `t_low_i` cycles and then high for `t_high_i` cycles. The high time of the eighth bit is extended by the framing intervals.
- R7: Each byte is preceded by `t_setup_i` cycles with the clock high and followed by `t_hold_i` cycles with the clock high. The first data byte follows the address hold directly with its setup, with no further gap. Mode changes only while the clock is high.
- R8: Before the second and any later data byte, the clock is held low for `t_halt_i` cycles. It then returns high, and that rising edge carries no bit, before the byte's setup interval. Data stays at the previous bit and mode stays high during the gap.
- R9: `busy_o` stays high from the cycle after the accepted start until the final hold interval ends. In the next cycle `done_o` is high for exactly one cycle, `busy_o` is low and the lines return to the R1 state.
- R10: A start while busy is ignored, and the transfer in progress continues unchanged. A start with a byte count of 0 or above `MAX_DATA` is ignored.
- R11: A timing count of zero behaves as a count of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transfer request pulse |
| ndata_i | input | IDX_W (2) | Number of data bytes, 1 to MAX_DATA |
| dev_i | input | DEV_W (6) | Device code, address bits 7:2 |
| grp_i | input | GRP_W (2) | Register-group selector, address bits 1:0 |
| data_i | input | 8*MAX_DATA (16) | Data bytes; byte k at bits 8k+7:8k |
| t_low_i | input | CNT_W (8) | Clock-low cycles per bit |
| t_high_i | input | CNT_W (8) | Clock-high cycles per bit |
| t_setup_i | input | CNT_W (8) | Setup cycles before each byte |
| t_hold_i | input | CNT_W (8) | Hold cycles after each byte |
| t_halt_i | input | CNT_W (8) | Halt gap cycles before later data bytes |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bus_clk_o | output | 1 | Serial bus clock |
| bus_dat_o | output | 1 | Serial bus data |
| bus_mode_o | output | 1 | Bus mode: low for address, high for data |
| bus_oe_o | output | 1 | Drive enable for the three lines |

## Verification
The bench measures every run of the bus clock level in cycles. A design that merged the address hold with a halt gap would fail these checks, as would one that left out the halt before the second data byte or lengthened the gap before the first data byte. The bench treats the clock return after a halt as a rising edge that carries no bit. A design that counted that edge as a bit, or sent bits in the wrong order, would shift every later bit and fail many rise checks. The bench also runs a transfer with all timing counts at zero, issues start requests during a transfer, and issues starts with a byte count of 0 or 3. A design that hung on zero counts, restarted during a transfer, or accepted a bad count would add unexpected runs or change the busy length.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_SETUP,
        ST_BLO,
        ST_BHI,
        ST_HOLD,
        ST_HALT
    } tw_state_e;
endpackage

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] INC   = 1;
    localparam logic [CNT_W:0]   INC_W = 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = restart_i ? '0 : cnt_q + INC;
        expire_o = (({1'b0, cnt_q} + INC_W) >= {1'b0, limit_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tw_byte_sel.sv
module tw_byte_sel #(
    parameter int MAX_DATA = 2,
    parameter int GRP_W    = 2,
    parameter int IDX_W    = 2
) (
    input  logic [8-GRP_W-1:0]    dev_i,
    input  logic [GRP_W-1:0]      grp_i,
    input  logic [MAX_DATA*8-1:0] data_i,
    input  logic [IDX_W-1:0]      sel_i,
    output logic [7:0]            byte_o
);
    always_comb begin
        byte_o = {dev_i, grp_i};
        for (int k = 0; k < MAX_DATA; k++) begin
            if (sel_i == IDX_W'(k + 1)) byte_o = data_i[k*8 +: 8];
        end
    end
endmodule

// File: rtl/tri_wire_ctl_master.sv
module tri_wire_ctl_master
    import tw_pkg::*;
#(
    parameter int MAX_DATA = 2,
    parameter int CNT_W    = 8,
    parameter int GRP_W    = 2,
    localparam int IDX_W   = $clog2(MAX_DATA + 1),
    localparam int DEV_W   = BYTE_W - GRP_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [IDX_W-1:0]       ndata_i,
    input  logic [DEV_W-1:0]       dev_i,
    input  logic [GRP_W-1:0]       grp_i,
    input  logic [MAX_DATA*8-1:0]  data_i,
    input  logic [CNT_W-1:0]       t_low_i,
    input  logic [CNT_W-1:0]       t_high_i,
    input  logic [CNT_W-1:0]       t_setup_i,
    input  logic [CNT_W-1:0]       t_hold_i,
    input  logic [CNT_W-1:0]       t_halt_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   bus_clk_o,
    output logic                   bus_dat_o,
    output logic                   bus_mode_o,
    output logic                   bus_oe_o
);
    localparam logic [IDX_W-1:0] MAXD     = IDX_W'(MAX_DATA);
    localparam logic [IDX_W-1:0] IDX_ONE  = 1;
    localparam logic [CNT_W-1:0] ONE_CYC  = 1;

    typedef struct packed {
        tw_state_e             st;
        logic [2:0]            bitc;
        logic [IDX_W-1:0]      idx;
        logic [IDX_W-1:0]      nd;
        logic [BYTE_W-1:0]     sh;
        logic [DEV_W-1:0]      dev;
        logic [GRP_W-1:0]      grp;
        logic [MAX_DATA*8-1:0] dbuf;
        logic                  bclk;
        logic                  bdat;
        logic                  bmode;
        logic                  boe;
        logic                  busy;
        logic                  done;
    } ctl_t;

    ctl_t             r_d, r_q;
    logic             restart;
    logic             expire;
    logic [CNT_W-1:0] limit;
    logic [7:0]       cur_byte;

    tw_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .limit_i   (limit),
        .expire_o  (expire)
    );

    tw_byte_sel #(.MAX_DATA(MAX_DATA), .GRP_W(GRP_W), .IDX_W(IDX_W)) u_sel (
        .dev_i  (r_q.dev),
        .grp_i  (r_q.grp),
        .data_i (r_q.dbuf),
        .sel_i  (r_q.idx),
        .byte_o (cur_byte)
    );

    always_comb begin
        unique case (r_q.st)
            ST_SETUP: limit = t_setup_i;
            ST_BLO:   limit = t_low_i;
            ST_BHI:   limit = t_high_i;
            ST_HOLD:  limit = t_hold_i;
            ST_HALT:  limit = t_halt_i;
            default:  limit = ONE_CYC;
        endcase
    end

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        restart = 1'b0;
        if (r_q.st == ST_IDLE) begin
            if (start_i && ndata_i != '0 && ndata_i <= MAXD) begin
                r_d.st    = ST_OPEN;
                r_d.nd    = ndata_i;
                r_d.dev   = dev_i;
                r_d.grp   = grp_i;
                r_d.dbuf  = data_i;
                r_d.idx   = '0;
                r_d.bclk  = 1'b1;
                r_d.bdat  = 1'b1;
                r_d.bmode = 1'b1;
                r_d.boe   = 1'b1;
                r_d.busy  = 1'b1;
                restart   = 1'b1;
            end
        end else if (expire) begin
            restart = 1'b1;
            unique case (r_q.st)
                ST_OPEN: begin
                    r_d.st    = ST_SETUP;
                    r_d.bmode = 1'b0;
                end
                ST_SETUP: begin
                    r_d.st   = ST_BLO;
                    r_d.bclk = 1'b0;
                    r_d.bdat = cur_byte[0];
                    r_d.sh   = cur_byte >> 1;
                    r_d.bitc = 3'd0;
                end
                ST_BLO: begin
                    r_d.st   = ST_BHI;
                    r_d.bclk = 1'b1;
                end
                ST_BHI: begin
                    if (r_q.bitc == 3'd7) begin
                        r_d.st = ST_HOLD;
                    end else begin
                        r_d.st   = ST_BLO;
                        r_d.bclk = 1'b0;
                        r_d.bdat = r_q.sh[0];
                        r_d.sh   = r_q.sh >> 1;
                        r_d.bitc = r_q.bitc + 3'd1;
                    end
                end
                ST_HOLD: begin
                    if (r_q.idx == r_q.nd) begin
                        r_d.st    = ST_IDLE;
                        r_d.bclk  = 1'b0;
                        r_d.bdat  = 1'b0;
                        r_d.bmode = 1'b0;
                        r_d.boe   = 1'b0;
                        r_d.busy  = 1'b0;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + IDX_ONE;
                        if (r_q.idx == '0) begin
                            r_d.st    = ST_SETUP;
                            r_d.bmode = 1'b1;
                        end else begin
                            r_d.st   = ST_HALT;
                            r_d.bclk = 1'b0;
                        end
                    end
                end
                ST_HALT: begin
                    r_d.st   = ST_SETUP;
                    r_d.bclk = 1'b1;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = r_q.busy;
    assign done_o     = r_q.done;
    assign bus_clk_o  = r_q.bclk;
    assign bus_dat_o  = r_q.bdat;
    assign bus_mode_o = r_q.bmode;
    assign bus_oe_o   = r_q.boe;

    // R1: idle means quiet lines
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!bus_clk_o && !bus_dat_o && !bus_mode_o && !bus_oe_o));

    // R2: opening cycle drives all lines high
    a_r2_open_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (bus_oe_o && bus_clk_o && bus_dat_o && bus_mode_o));

    // R3: data moves only while the bus clock is low
    a_r3_data_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && bus_dat_o != $past(bus_dat_o)) |-> !bus_clk_o);

    // R7: mode moves only while the bus clock stays high
    a_r7_mode_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && bus_mode_o != $past(bus_mode_o))
            |-> (bus_clk_o && $past(bus_clk_o)));

    // R9: done is a single-cycle pulse that comes with the fall of busy
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r9_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R10: a transfer only begins from a start request
    a_r10_start_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

// File: tb/tri_wire_ctl_master_tb_top.sv
module tri_wire_ctl_master_tb_top;
    localparam int MAX_DATA = 2;
    localparam int CNT_W    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  ndata_i = '0;
    logic [5:0]  dev_i = '0;
    logic [1:0]  grp_i = '0;
    logic [15:0] data_i = '0;
    logic [7:0]  t_low_i = 8'd1, t_high_i = 8'd1, t_setup_i = 8'd1, t_hold_i = 8'd1, t_halt_i = 8'd1;
    logic busy_o, done_o, bus_clk_o, bus_dat_o, bus_mode_o, bus_oe_o;

    always #5 clk = ~clk;

    tri_wire_ctl_master #(.MAX_DATA(MAX_DATA), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ndata_i(ndata_i),
        .dev_i(dev_i), .grp_i(grp_i), .data_i(data_i),
        .t_low_i(t_low_i), .t_high_i(t_high_i), .t_setup_i(t_setup_i),
        .t_hold_i(t_hold_i), .t_halt_i(t_halt_i),
        .busy_o(busy_o), .done_o(done_o), .bus_clk_o(bus_clk_o),
        .bus_dat_o(bus_dat_o), .bus_mode_o(bus_mode_o), .bus_oe_o(bus_oe_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // scoreboard queues
    bit    exp_lvl[$];
    int    exp_len[$];
    string exp_rtag[$];
    bit    exp_rdat[$];
    bit    exp_rmode[$];
    string exp_btag[$];
    int    exp_total = 0;
    bit    done_seen = 0;

    function automatic int eff(input logic [7:0] t);
        return (t == 0) ? 1 : int'(t);
    endfunction

    task automatic push_run(input bit lvl, input int len, input string tag);
        exp_lvl.push_back(lvl);
        exp_len.push_back(len);
        exp_rtag.push_back(tag);
        exp_total += len;
    endtask

    task automatic push_rise(input bit d, input bit m, input string tag);
        exp_rdat.push_back(d);
        exp_rmode.push_back(m);
        exp_btag.push_back(tag);
    endtask

    // driver: builds the expected line activity, then issues the request
    task automatic run_xfer(input logic [5:0] dev, input logic [1:0] grp, input int nd,
                            input logic [15:0] dat, input int l, input int h, input int s,
                            input int ho, input int ha, input bit poke);
        logic [7:0] bytes [3];
        int L, H, S, HO, HA;
        t_low_i = 8'(l); t_high_i = 8'(h); t_setup_i = 8'(s); t_hold_i = 8'(ho); t_halt_i = 8'(ha);
        L = eff(t_low_i); H = eff(t_high_i); S = eff(t_setup_i); HO = eff(t_hold_i); HA = eff(t_halt_i);
        bytes[0] = {dev, grp};
        bytes[1] = dat[7:0];
        bytes[2] = dat[15:8];
        exp_total = 0;
        push_run(1'b1, 1 + S, "R2/R7 open+setup");
        for (int b = 0; b <= nd; b++) begin
            for (int i = 0; i < 8; i++) begin
                push_run(1'b0, L, "R6 bit low");
                push_rise(bytes[b][i], (b != 0), (b == 0) ? "R3/R4 addr bit" : "R3/R5 data bit");
                if (i < 7) push_run(1'b1, H, "R6 bit high");
                else if (b == nd) push_run(1'b1, H + HO, "R7 last hold");
                else if (b == 0) push_run(1'b1, H + HO + S, "R7 addr hold+setup");
                else begin
                    push_run(1'b1, H + HO, "R7 hold before halt");
                    push_run(1'b0, HA, "R8 halt low");
                    push_rise(bytes[b][7], 1'b1, "R8 halt edge");
                    push_run(1'b1, S, "R8 setup after halt");
                end
            end
        end
        done_seen = 0;
        @(negedge clk);
        dev_i = dev; grp_i = grp; data_i = dat; ndata_i = 2'(nd); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            dev_i = ~dev; data_i = ~dat; ndata_i = 2'd1; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (9) @(negedge clk);
            ndata_i = 2'd2; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_seen) @(negedge clk);
        check(exp_len.size() == 0, "R9 runs left", exp_len.size(), 0);
        check(exp_rdat.size() == 0, "R3 rises left", exp_rdat.size(), 0);
        repeat (3) @(negedge clk);
        check(!busy_o && !bus_oe_o && !bus_clk_o && !bus_dat_o && !bus_mode_o,
              poke ? "R10 no restart after ignored start" : "R1 idle after transfer",
              int'({busy_o, bus_oe_o, bus_clk_o, bus_dat_o, bus_mode_o}), 0);
    endtask

    // monitor
    bit prev_oe = 0, prev_clk = 0, prev_done = 0;
    bit run_lvl = 0;
    int run_len = 0;
    int busy_cyc = 0;

    task automatic emit_run(input bit lvl, input int len);
        if (exp_len.size() == 0) begin
            check(1'b0, "R9 unexpected clock run", len, 0);
        end else begin
            bit el; int en; string tg;
            el = exp_lvl.pop_front(); en = exp_len.pop_front(); tg = exp_rtag.pop_front();
            check(lvl == el && len == en, tg, int'(lvl) * 10000 + len, int'(el) * 10000 + en);
        end
    endtask

    task automatic emit_rise(input bit d, input bit m);
        if (exp_rdat.size() == 0) begin
            check(1'b0, "R3 unexpected rising edge", 1, 0);
        end else begin
            bit ed, em; string tg;
            ed = exp_rdat.pop_front(); em = exp_rmode.pop_front(); tg = exp_btag.pop_front();
            check(d == ed && m == em, tg, int'({m, d}), int'({em, ed}));
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_oe_o) begin
                if (!prev_oe) begin
                    check(busy_o && bus_clk_o && bus_dat_o && bus_mode_o, "R2 open state",
                          int'({busy_o, bus_clk_o, bus_dat_o, bus_mode_o}), 15);
                    run_lvl = bus_clk_o; run_len = 1;
                end else if (bus_clk_o == prev_clk) begin
                    run_len++;
                end else begin
                    emit_run(run_lvl, run_len);
                    if (bus_clk_o) emit_rise(bus_dat_o, bus_mode_o);
                    run_lvl = bus_clk_o; run_len = 1;
                end
            end else if (prev_oe) begin
                emit_run(run_lvl, run_len);
            end
            if (busy_o) busy_cyc++;
            if (done_o) begin
                check(!busy_o, "R9 busy low at done", int'(busy_o), 0);
                check(busy_cyc == exp_total, "R9 busy length", busy_cyc, exp_total);
                busy_cyc = 0;
                done_seen = 1;
            end
            if (done_o && prev_done) check(1'b0, "R9 done longer than one cycle", 2, 1);
            prev_oe = bus_oe_o; prev_clk = bus_clk_o; prev_done = done_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL R9 watchdog expired: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !bus_oe_o && !bus_clk_o && !bus_dat_o && !bus_mode_o,
              "R1 reset state", int'({busy_o, done_o, bus_oe_o, bus_clk_o, bus_dat_o, bus_mode_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_xfer(6'h05, 2'd2, 1, 16'h00A5, 2, 3, 2, 2, 4, 1'b0);
        run_xfer(6'h2A, 2'd1, 2, 16'h813C, 1, 1, 1, 1, 1, 1'b0);
        // R11: all counts zero behave as one cycle
        run_xfer(6'h3F, 2'd0, 2, 16'h00FF, 0, 0, 0, 0, 0, 1'b0);
        // R10: starts issued mid-transfer must not disturb it
        run_xfer(6'h11, 2'd3, 2, 16'h6E93, 3, 2, 4, 3, 5, 1'b1);

        // R10: byte count of 0 or above the maximum is refused
        @(negedge clk);
        ndata_i = 2'd0; start_i = 1'b1;
        @(negedge clk);
        ndata_i = 2'd3;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check(!busy_o && !bus_oe_o, "R10 bad count ignored", int'({busy_o, bus_oe_o}), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule